// File: doc/BRIEF.md
# E3 Receive Frame Alignment Supervisor

This block is the synchronization controller that sits behind the frame-alignment correlator of an E3 receive framer. Once per frame period it gets a strobe, a flag that says whether the alignment word was seen where it was expected, and the bit position where it was seen. From these it decides whether the receiver is searching, verifying a candidate, in frame, out of frame, or has lost frame. It drives two alarm pins that report this result.

It also keeps two byte-wide registers. The first is a configuration and status byte. It holds a writable dwell-limit select and shows the current out-of-frame, loss-of-frame, loss-of-signal, alarm-indication and far-end-failure conditions. The second is an event byte whose bits latch state changes and clear when the byte is read. The line-condition flags come in as plain inputs from other detectors.

When alignment is lost, the search restarts right away. The loss-of-frame alarm is only raised if the out-of-frame state lasts longer than the selected number of frame periods, either 24 or 8.

Top module: `e3_frame_align`

## Requirements
- R1: After reset both alarm pins are high, the status byte reads 0x60 (bit 6 loss-of-frame, bit 5 out-of-frame), and the event byte reads 0x00.
- R2: In frame is declared on the third consecutive frame strobe that reports the alignment word at one and the same position. A strobe that reports a miss, or a different position, returns the block to search. The next hit then counts as the first.
- R3: When in frame is declared, both alarm pins go low, status bits 6 and 5 clear, and event bits 3 and 2 are set.
- R4: While in frame, four consecutive frames with a miss raise the out-of-frame pin and status bit 5 and set event bit 3. A frame with a hit restarts that run of misses.
- R5: Status bit 7 is writable and resets to 0. With 0, loss of frame is declared on the 24th frame strobe after entry to out-of-frame if frame has not been regained. With 1, it is declared on the 8th. Loss of frame raises the loss-of-frame pin and status bit 6 and sets event bit 2.
- R6: On loss of frame any candidate alignment under verification is discarded and the search restarts. A fresh run of three hits is then needed.
- R7: If frame is regained before the dwell limit, no loss of frame is declared.
- R8: Event bit 4 is set when in frame is declared at a position different from the last position held in frame. It is not set on the first acquisition after reset or when the same position is regained.
- R9: Asserting the read strobe clears the event byte in the next cycle. An event that arrives in the same cycle as the read stays set.
- R10: Status bits 4, 3 and 0 follow the loss-of-signal, alarm-indication and far-end-failure inputs one cycle later. Every change of the loss-of-signal input sets event bit 1, and every change of the alarm-indication input sets event bit 0.
- R11: Status bits 2 and 1 and event bits 7 to 5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStrobe | input | 1 | One-cycle pulse per frame period |
| fasOk | input | 1 | Alignment word found in this frame (qualified by frameStrobe) |
| fasPos | input | POS_W | Bit position at which the word was found |
| losIn | input | 1 | Loss-of-signal condition |
| aisIn | input | 1 | Alarm-indication condition |
| ferfIn | input | 1 | Far-end-failure condition |
| cfgWrEn | input | 1 | Write strobe for the configuration byte |
| cfgWrData | input | 8 | Write data; only bit 7 is stored |
| intRdEn | input | 1 | Read strobe for the event byte (clear on read) |
| oofPin | output | 1 | Out-of-frame alarm |
| lofPin | output | 1 | Loss-of-frame alarm |
| cfgStatus | output | 8 | Configuration and status byte |
| intStatus | output | 8 | Event byte |

## Verification
The bench probes the exact frame on which each limit fires: the third hit, the fourth miss, and the 8th or 24th dwell strobe. A design that is off by one there declares or escalates a frame early or late. It breaks runs of misses with a single hit, and breaks candidate verification with a position change, so that a counter which is not cleared would be exposed. It lets loss of frame strike while a candidate is two hits into verification, which catches a design that keeps that candidate. It also issues a read in the same cycle as an out-of-frame event, to catch an event byte that drops the event, and regains frame both at the old position and at a new one to separate a correct change-of-alignment flag from one that fires always or never.

// File: rtl/e3fa_pkg.sv
package e3fa_pkg;

  typedef enum logic [1:0] {
    ST_SEARCH  = 2'd0,
    ST_CHECK   = 2'd1,
    ST_INFRAME = 2'd2
  } alignState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCand;
    logic incHit;
    logic clrErr;
    logic incErr;
    logic goOof;
    logic incDwell;
    logic goLof;
    logic inFrame;
  } alignCmd_t;

  // conditions from datapath to control
  typedef struct packed {
    logic posMatch;
    logic hitLast;
    logic errLast;
    logic dwellLast;
    logic dwelling;
  } alignSense_t;

endpackage

// File: rtl/e3fa_ctrl.sv
module e3fa_ctrl
  import e3fa_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameStrobe,
  input  logic        fasOk,
  input  alignSense_t sense,
  output alignCmd_t   cmd
);

  alignState_e stateQ, stateNext;

  always_comb begin
    cmd       = '0;
    stateNext = stateQ;
    if (frameStrobe) begin
      case (stateQ)
        ST_SEARCH: begin
          if (fasOk) begin
            cmd.loadCand = 1'b1;
            stateNext    = ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (fasOk && sense.posMatch) begin
            if (sense.hitLast) begin
              cmd.inFrame = 1'b1;
              stateNext   = ST_INFRAME;
            end else begin
              cmd.incHit = 1'b1;
            end
          end else begin
            stateNext = ST_SEARCH;
          end
        end
        ST_INFRAME: begin
          if (!fasOk) begin
            if (sense.errLast) begin
              cmd.goOof = 1'b1;
              stateNext = ST_SEARCH;
            end else begin
              cmd.incErr = 1'b1;
            end
          end else begin
            cmd.clrErr = 1'b1;
          end
        end
        default: stateNext = ST_SEARCH;
      endcase
      // out-of-frame dwell: regaining frame wins over escalation
      if (stateQ != ST_INFRAME && sense.dwelling && !cmd.inFrame) begin
        if (sense.dwellLast) begin
          cmd.goLof    = 1'b1;
          cmd.loadCand = 1'b0;
          cmd.incHit   = 1'b0;
          stateNext    = ST_SEARCH;
        end else begin
          cmd.incDwell = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_SEARCH;
    else       stateQ <= stateNext;
  end

  // R2: in frame is only ever entered from candidate verification
  a_r2_entry_from_check: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_INFRAME && $past(stateQ) != ST_INFRAME) |-> $past(stateQ) == ST_CHECK);

  // R6: loss of frame always restarts the search
  a_r6_lof_restarts: assert property (@(posedge clk) disable iff (!rstN)
    cmd.goLof |=> stateQ == ST_SEARCH);

endmodule

// File: rtl/e3fa_dp.sv
module e3fa_dp
  import e3fa_pkg::*;
#(
  parameter int POS_W       = 11,
  parameter int SEARCH_HITS = 3,
  parameter int LOSS_ERRS   = 4,
  parameter int DWELL_LONG  = 24,
  parameter int DWELL_SHORT = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [POS_W-1:0] fasPos,
  input  alignCmd_t        cmd,
  input  logic             losIn,
  input  logic             aisIn,
  input  logic             ferfIn,
  input  logic             cfgWrEn,
  input  logic [7:0]       cfgWrData,
  input  logic             intRdEn,
  output alignSense_t      sense,
  output logic             oofFlag,
  output logic             lofFlag,
  output logic [7:0]       cfgStatus,
  output logic [7:0]       intStatus
);

  localparam int HIT_W = $clog2(SEARCH_HITS + 1);
  localparam int ERR_W = $clog2(LOSS_ERRS + 1);
  localparam int DW_W  = $clog2(DWELL_LONG + 1);
  localparam int EVT_W = 5;

  logic [POS_W-1:0] candQ, heldPos;
  logic             heldValid;
  logic [HIT_W-1:0] hitCnt;
  logic [ERR_W-1:0] errCnt;
  logic [DW_W-1:0]  dwellCnt, dwellLimit;
  logic             algoSel, losQ, aisQ, ferfQ;
  logic [EVT_W-1:0] intQ, evt;

  assign dwellLimit = algoSel ? DW_W'(DWELL_SHORT - 1) : DW_W'(DWELL_LONG - 1);

  assign sense.posMatch  = (fasPos == candQ);
  assign sense.hitLast   = (hitCnt == HIT_W'(SEARCH_HITS - 1));
  assign sense.errLast   = (errCnt == ERR_W'(LOSS_ERRS - 1));
  assign sense.dwellLast = (dwellCnt == dwellLimit);
  assign sense.dwelling  = oofFlag && !lofFlag;

  // candidate alignment and verification run
  always_ff @(posedge clk) begin
    if (!rstN) begin
      candQ  <= '0;
      hitCnt <= '0;
    end else if (cmd.loadCand) begin
      candQ  <= fasPos;
      hitCnt <= HIT_W'(1);
    end else if (cmd.incHit) begin
      hitCnt <= hitCnt + 1'b1;
    end
  end

  // run of consecutive misses while in frame
  always_ff @(posedge clk) begin
    if (!rstN || cmd.clrErr || cmd.inFrame) errCnt <= '0;
    else if (cmd.incErr)                    errCnt <= errCnt + 1'b1;
  end

  // out-of-frame dwell
  always_ff @(posedge clk) begin
    if (!rstN || cmd.goOof) dwellCnt <= '0;
    else if (cmd.incDwell)  dwellCnt <= dwellCnt + 1'b1;
  end

  // alarm flags and the last position held in frame
  always_ff @(posedge clk) begin
    if (!rstN) begin
      oofFlag   <= 1'b1;
      lofFlag   <= 1'b1;
      heldPos   <= '0;
      heldValid <= 1'b0;
    end else begin
      if (cmd.goOof) oofFlag <= 1'b1;
      if (cmd.goLof) lofFlag <= 1'b1;
      if (cmd.inFrame) begin
        oofFlag   <= 1'b0;
        lofFlag   <= 1'b0;
        heldPos   <= candQ;
        heldValid <= 1'b1;
      end
    end
  end

  // configuration and line-condition samples
  always_ff @(posedge clk) begin
    if (!rstN) begin
      algoSel <= 1'b0;
      losQ    <= 1'b0;
      aisQ    <= 1'b0;
      ferfQ   <= 1'b0;
    end else begin
      if (cfgWrEn) algoSel <= cfgWrData[7];
      losQ  <= losIn;
      aisQ  <= aisIn;
      ferfQ <= ferfIn;
    end
  end

  // event byte: new events win over a simultaneous read
  always_comb begin
    evt[4] = cmd.inFrame && heldValid && (candQ != heldPos);
    evt[3] = cmd.goOof || cmd.inFrame;
    evt[2] = cmd.goLof || cmd.inFrame;
    evt[1] = losIn ^ losQ;
    evt[0] = aisIn ^ aisQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) intQ <= '0;
    else       intQ <= (intRdEn ? '0 : intQ) | evt;
  end

  assign cfgStatus = {algoSel, lofFlag, oofFlag, losQ, aisQ, 2'b00, ferfQ};
  assign intStatus = {3'b000, intQ};

  // R5: loss of frame is only ever reported together with out of frame
  a_r5_lof_within_oof: assert property (@(posedge clk) disable iff (!rstN)
    lofFlag |-> oofFlag);

  // R5: loss of frame rises only when the dwell count sat at the limit
  a_r5_lof_at_limit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lofFlag) |-> $past(dwellCnt == dwellLimit));

  // R3: declaring in frame drops both alarms
  a_r3_inframe_clears: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmd.inFrame) |-> (!oofFlag && !lofFlag));

  // R9: an out-of-frame event survives a read in the same cycle
  a_r9_event_kept: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmd.goOof) |-> intQ[3]);

  // R8: change of alignment needs a previously held position
  a_r8_cofa_history: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intQ[4]) |-> heldValid);

endmodule

// File: rtl/e3_frame_align.sv
module e3_frame_align
  import e3fa_pkg::*;
#(
  parameter int POS_W       = 11,
  parameter int SEARCH_HITS = 3,
  parameter int LOSS_ERRS   = 4,
  parameter int DWELL_LONG  = 24,
  parameter int DWELL_SHORT = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStrobe,
  input  logic             fasOk,
  input  logic [POS_W-1:0] fasPos,
  input  logic             losIn,
  input  logic             aisIn,
  input  logic             ferfIn,
  input  logic             cfgWrEn,
  input  logic [7:0]       cfgWrData,
  input  logic             intRdEn,
  output logic             oofPin,
  output logic             lofPin,
  output logic [7:0]       cfgStatus,
  output logic [7:0]       intStatus
);

  alignCmd_t   cmd;
  alignSense_t sense;
  logic        oofFlag, lofFlag;

  e3fa_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStrobe(frameStrobe),
    .fasOk      (fasOk),
    .sense      (sense),
    .cmd        (cmd)
  );

  e3fa_dp #(
    .POS_W      (POS_W),
    .SEARCH_HITS(SEARCH_HITS),
    .LOSS_ERRS  (LOSS_ERRS),
    .DWELL_LONG (DWELL_LONG),
    .DWELL_SHORT(DWELL_SHORT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .fasPos   (fasPos),
    .cmd      (cmd),
    .losIn    (losIn),
    .aisIn    (aisIn),
    .ferfIn   (ferfIn),
    .cfgWrEn  (cfgWrEn),
    .cfgWrData(cfgWrData),
    .intRdEn  (intRdEn),
    .sense    (sense),
    .oofFlag  (oofFlag),
    .lofFlag  (lofFlag),
    .cfgStatus(cfgStatus),
    .intStatus(intStatus)
  );

  assign oofPin = oofFlag;
  assign lofPin = lofFlag;

endmodule

// File: tb/e3_frame_align_tb.sv
`timescale 1ns/1ps
module e3_frame_align_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStrobe = 1'b0, fasOk = 1'b0;
  logic [10:0] fasPos = '0;
  logic        losIn = 1'b0, aisIn = 1'b0, ferfIn = 1'b0;
  logic        cfgWrEn = 1'b0, intRdEn = 1'b0;
  logic [7:0]  cfgWrData = '0;
  logic        oofPin, lofPin;
  logic [7:0]  cfgStatus, intStatus;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  e3_frame_align u_dut (
    .clk(clk), .rstN(rstN), .frameStrobe(frameStrobe), .fasOk(fasOk),
    .fasPos(fasPos), .losIn(losIn), .aisIn(aisIn), .ferfIn(ferfIn),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .intRdEn(intRdEn),
    .oofPin(oofPin), .lofPin(lofPin), .cfgStatus(cfgStatus), .intStatus(intStatus)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; frameStrobe = 1'b0; fasOk = 1'b0; intRdEn = 1'b0; cfgWrEn = 1'b0;
    losIn = 1'b0; aisIn = 1'b0; ferfIn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic frm(input bit ok, input int pos);
    @(negedge clk);
    frameStrobe = 1'b1; fasOk = ok; fasPos = pos[10:0];
    @(negedge clk);
    frameStrobe = 1'b0; fasOk = 1'b0;
  endtask

  task automatic clrInt();
    @(negedge clk); intRdEn = 1'b1;
    @(negedge clk); intRdEn = 1'b0;
  endtask

  task automatic acquire(input int pos);
    repeat (3) frm(1'b1, pos);
  endtask

  task automatic lose();
    repeat (4) frm(1'b0, 0);
  endtask

  task automatic testReset();
    doReset();
    @(negedge clk);
    chk("R1 oof pin", {7'd0, oofPin}, 8'h01);
    chk("R1 lof pin", {7'd0, lofPin}, 8'h01);
    chk("R1 status", cfgStatus, 8'h60);
    chk("R1 events", intStatus, 8'h00);
  endtask

  task automatic testAcquire();
    doReset();
    frm(1'b1, 4); frm(1'b0, 0);
    frm(1'b1, 4); frm(1'b1, 4);
    chk("R2 miss restarts run", {7'd0, oofPin}, 8'h01);
    frm(1'b1, 4);
    chk("R2 third hit declares", {7'd0, oofPin}, 8'h00);
    chk("R3 lof pin low", {7'd0, lofPin}, 8'h00);
    chk("R3 status cleared", cfgStatus, 8'h00);
    chk("R3 events", intStatus, 8'h0C);
    clrInt();
    chk("R9 read clears", intStatus, 8'h00);
    doReset();
    frm(1'b1, 4); frm(1'b1, 6); frm(1'b1, 6); frm(1'b1, 6);
    chk("R2 position change restarts", {7'd0, oofPin}, 8'h01);
    frm(1'b1, 6);
    chk("R2 new position declared", {7'd0, oofPin}, 8'h00);
  endtask

  task automatic testLoss();
    doReset();
    acquire(12); clrInt();
    repeat (3) frm(1'b0, 0);
    frm(1'b1, 12);
    repeat (3) frm(1'b0, 0);
    chk("R4 hit breaks miss run", {7'd0, oofPin}, 8'h00);
    frm(1'b0, 0);
    chk("R4 fourth miss oof pin", {7'd0, oofPin}, 8'h01);
    chk("R4 lof pin stays low", {7'd0, lofPin}, 8'h00);
    chk("R4 status", cfgStatus, 8'h20);
    chk("R4 event", intStatus, 8'h08);
    clrInt();
    repeat (23) frm(1'b0, 0);
    chk("R5 long dwell not yet", {7'd0, lofPin}, 8'h00);
    frm(1'b0, 0);
    chk("R5 long dwell lof pin", {7'd0, lofPin}, 8'h01);
    chk("R5 long dwell status", cfgStatus, 8'h60);
    chk("R5 long dwell event", intStatus, 8'h04);
  endtask

  task automatic testShortDwell();
    doReset();
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = 8'h80;
    @(negedge clk); cfgWrEn = 1'b0;
    chk("R5 select bit written", cfgStatus, 8'hE0);
    acquire(3); lose(); clrInt();
    repeat (6) frm(1'b0, 0);
    frm(1'b1, 3);
    chk("R5 short dwell not yet", {7'd0, lofPin}, 8'h00);
    frm(1'b1, 3);
    chk("R5 short dwell lof pin", {7'd0, lofPin}, 8'h01);
    frm(1'b1, 3); frm(1'b1, 3);
    chk("R6 candidate discarded", {7'd0, oofPin}, 8'h01);
    frm(1'b1, 3);
    chk("R6 fresh run declares", {7'd0, oofPin}, 8'h00);
    chk("R6 lof pin cleared", {7'd0, lofPin}, 8'h00);
    chk("R8 same position no change flag", intStatus, 8'h0C);
  endtask

  task automatic testRegain();
    doReset();
    acquire(5); clrInt();
    lose();
    acquire(5);
    chk("R7 regained oof pin", {7'd0, oofPin}, 8'h00);
    chk("R7 no lof event", intStatus, 8'h0C);
    lose(); clrInt();
    acquire(9);
    chk("R8 new position change flag", intStatus, 8'h1C);
  endtask

  task automatic testCollision();
    doReset();
    acquire(2);
    repeat (3) frm(1'b0, 0);
    clrInt();
    @(negedge clk);
    frameStrobe = 1'b1; fasOk = 1'b0; intRdEn = 1'b1;
    @(negedge clk);
    frameStrobe = 1'b0; intRdEn = 1'b0;
    chk("R9 event kept over read", intStatus, 8'h08);
  endtask

  task automatic testLine();
    doReset();
    @(negedge clk); losIn = 1'b1;
    @(negedge clk);
    chk("R10 los status", cfgStatus, 8'h70);
    chk("R10 los event", intStatus, 8'h02);
    aisIn = 1'b1;
    @(negedge clk);
    chk("R10 ais status", cfgStatus, 8'h78);
    chk("R10 ais event", intStatus, 8'h03);
    ferfIn = 1'b1;
    @(negedge clk);
    chk("R10 ferf status, R11 spare bits", cfgStatus, 8'h79);
    chk("R10 ferf raises no event", intStatus, 8'h03);
    clrInt();
    losIn = 1'b0;
    @(negedge clk);
    chk("R10 los falling event", intStatus, 8'h02);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testAcquire();
    testLoss();
    testShortDwell();
    testRegain();
    testCollision();
    testLine();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule